// File: doc/BRIEF.md
# Packet Latency Tracker and Receptor

This block measures how long each packet spends between entering a source queue and reaching its destination. On injection, the current network cycle is written into a timestamp table. The table is addressed first by the source node number and then by the packet number. Each slot also has an occupancy bit, which is set at that moment.

When a tail flit arrives, the block compares the packet's destination with the number of the receiving node. It then looks up the slot for that source and packet number. For a good arrival it reports the elapsed cycles, together with the source and packet numbers, and releases the slot. Because a slot stays occupied until its packet arrives, the width of the packet number bounds how many packets one source can have outstanding.

Every arrival produces exactly one registered result on the clock edge after it is presented. The result is either a latency report, a destination error or a stale-slot error.

Top module: `pkt_latency_tracker`

## Requirements
- R1: After reset, all result outputs are zero and every slot is empty, so any arrival with a matching destination reports a stale-slot error.
- R2: An injection stores `net_cycle` in slot (`inj_src`, `inj_pid`). A later arrival for that slot with `arr_dest == rx_node` pulses `lat_valid` on the next clock. In that cycle `lat_cycles` equals the arrival-cycle `net_cycle` minus the stored stamp, and `lat_src`/`lat_pid` echo the arrival.
- R3: The latency is the difference modulo 2^TS_W (2^16 by default), so a packet that spans a counter wrap reports its true elapsed cycles.
- R4: An arrival whose `arr_dest` differs from `rx_node` pulses only `err_dest` on the next clock and leaves its slot untouched.
- R5: An arrival with a matching destination on an empty slot pulses only `err_stale` on the next clock.
- R6: A reported arrival empties its slot, so a repeated arrival for the same slot reports a stale-slot error.
- R7: When an injection and an arrival for the same slot happen in the same cycle, the arrival sees the new stamp: `lat_valid` with latency 0. The slot is empty afterwards.
- R8: Slots are independent. Each of the NODES x 2^PID_W slots keeps its own stamp and occupancy, whatever the order of injections and arrivals.
- R9: Injecting into an occupied slot replaces its stamp, and the slot stays occupied.
- R10: `lat_valid`, `err_dest` and `err_stale` are single-cycle pulses, at most one at a time, and all are low in the cycle after a clock with `arr_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| net_cycle | input | TS_W | Current network cycle count |
| rx_node | input | NODE_W | Number of the receiving node |
| inj_valid | input | 1 | Packet entered a source queue this cycle |
| inj_src | input | NODE_W | Source node of the injected packet |
| inj_pid | input | PID_W | Packet number of the injected packet |
| arr_valid | input | 1 | Tail flit arrived this cycle |
| arr_src | input | NODE_W | Source node carried by the arriving packet |
| arr_pid | input | PID_W | Packet number carried by the arriving packet |
| arr_dest | input | NODE_W | Destination carried by the arriving packet |
| lat_valid | output | 1 | Latency report pulse |
| lat_cycles | output | TS_W | Measured latency in cycles |
| lat_src | output | NODE_W | Source of the reported arrival |
| lat_pid | output | PID_W | Packet number of the reported arrival |
| err_dest | output | 1 | Destination mismatch pulse |
| err_stale | output | 1 | Arrival on an empty slot pulse |

## Verification
A corrupted occupancy bit cannot be seen until the next arrival for that slot. That arrival then shows either a spurious stale-slot error or a latency report where an error belongs. The bench therefore sweeps every slot through fill, drain and re-drain, so the fault appears one clock after the next arrival.

A wrong stamp or a broken bypass path shows directly as a wrong `lat_cycles` in the report cycle. Wraparound, overwrite and same-cycle cases are each measured against arithmetic the bench does itself. A fault in the destination check can hide a slot release. This is caught because a correct arrival that follows a mismatched one must still succeed.

// File: rtl/lt_pkg.sv
package lt_pkg;
   // Outcome of one arrival, decided in the same cycle it is presented.
   typedef enum logic [1:0] {
      ARR_NONE     = 2'd0,
      ARR_OK       = 2'd1,
      ARR_BAD_DEST = 2'd2,
      ARR_STALE    = 2'd3
   } arr_kind_e;
endpackage

// File: rtl/lt_stamp_table.sv
module lt_stamp_table #(
   parameter int NODES  = 4,
   parameter int PID_W  = 2,
   parameter int TS_W   = 16,
   parameter int NODE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [NODE_W-1:0] wr_src,
   input  logic [PID_W-1:0]  wr_pid,
   input  logic [TS_W-1:0]   wr_ts,
   input  logic [NODE_W-1:0] rd_src,
   input  logic [PID_W-1:0]  rd_pid,
   input  logic              clr_en,
   output logic [TS_W-1:0]   rd_ts,
   output logic              rd_vld
);
   localparam int SLOTS = 1 << PID_W;

   logic [TS_W-1:0]  row_ts  [NODES];
   logic [NODES-1:0] row_vld;

   // One row of stamps and occupancy bits per source node.
   for (genvar r = 0; r < NODES; r++) begin : g_row
      logic [TS_W-1:0]  ts_q [SLOTS];
      logic [SLOTS-1:0] vld_q;
      logic             row_wr;
      logic             row_clr;

      assign row_wr  = wr_en  && (wr_src == NODE_W'(r));
      assign row_clr = clr_en && (rd_src == NODE_W'(r));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q <= '0;
         end else begin
            if (row_wr)  vld_q[wr_pid] <= 1'b1;
            // release after set: an arrival consuming a same-cycle write empties the slot
            if (row_clr) vld_q[rd_pid] <= 1'b0;
         end
      end

      always_ff @(posedge clk) begin
         if (row_wr) ts_q[wr_pid] <= wr_ts;
      end

      assign row_ts[r]  = ts_q[rd_pid];
      assign row_vld[r] = vld_q[rd_pid];
   end

   logic same_slot;
   logic src_in_range;

   assign same_slot    = wr_en && (wr_src == rd_src) && (wr_pid == rd_pid);
   assign src_in_range = (int'(rd_src) < NODES);

   always_comb begin
      if (same_slot) begin
         rd_ts  = wr_ts;
         rd_vld = 1'b1;
      end else if (src_in_range) begin
         rd_ts  = row_ts[rd_src];
         rd_vld = row_vld[rd_src];
      end else begin
         rd_ts  = '0;
         rd_vld = 1'b0;
      end
   end
endmodule

// File: rtl/lt_latency_calc.sv
module lt_latency_calc
   import lt_pkg::*;
#(
   parameter int PID_W  = 2,
   parameter int TS_W   = 16,
   parameter int NODE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arr_valid,
   input  logic [NODE_W-1:0] arr_src,
   input  logic [PID_W-1:0]  arr_pid,
   input  logic [NODE_W-1:0] arr_dest,
   input  logic [NODE_W-1:0] rx_node,
   input  logic [TS_W-1:0]   now,
   input  logic [TS_W-1:0]   rd_ts,
   input  logic              rd_vld,
   output logic              clr_en,
   output logic              lat_valid,
   output logic [TS_W-1:0]   lat_cycles,
   output logic [NODE_W-1:0] lat_src,
   output logic [PID_W-1:0]  lat_pid,
   output logic              err_dest,
   output logic              err_stale
);
   arr_kind_e       kind;
   logic [TS_W-1:0] delta;

   always_comb begin
      if (!arr_valid)              kind = ARR_NONE;
      else if (arr_dest != rx_node) kind = ARR_BAD_DEST;
      else if (!rd_vld)            kind = ARR_STALE;
      else                         kind = ARR_OK;
   end

   // TS_W-bit subtraction wraps naturally
   assign delta  = now - rd_ts;
   assign clr_en = (kind == ARR_OK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_valid  <= 1'b0;
         err_dest   <= 1'b0;
         err_stale  <= 1'b0;
         lat_cycles <= '0;
         lat_src    <= '0;
         lat_pid    <= '0;
      end else begin
         lat_valid  <= (kind == ARR_OK);
         err_dest   <= (kind == ARR_BAD_DEST);
         err_stale  <= (kind == ARR_STALE);
         lat_cycles <= (kind == ARR_OK) ? delta : '0;
         if (arr_valid) begin
            lat_src <= arr_src;
            lat_pid <= arr_pid;
         end
      end
   end
endmodule

// File: rtl/pkt_latency_tracker.sv
module pkt_latency_tracker #(
   parameter int NODES  = 4,
   parameter int PID_W  = 2,
   parameter int TS_W   = 16,
   localparam int NODE_W = (NODES > 1) ? $clog2(NODES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TS_W-1:0]   net_cycle,
   input  logic [NODE_W-1:0] rx_node,
   input  logic              inj_valid,
   input  logic [NODE_W-1:0] inj_src,
   input  logic [PID_W-1:0]  inj_pid,
   input  logic              arr_valid,
   input  logic [NODE_W-1:0] arr_src,
   input  logic [PID_W-1:0]  arr_pid,
   input  logic [NODE_W-1:0] arr_dest,
   output logic              lat_valid,
   output logic [TS_W-1:0]   lat_cycles,
   output logic [NODE_W-1:0] lat_src,
   output logic [PID_W-1:0]  lat_pid,
   output logic              err_dest,
   output logic              err_stale
);
   if (NODES < 2 || NODES > 256) begin : g_bad_nodes
      $error("NODES must lie in 2..256");
   end
   if (PID_W < 1 || PID_W > 8) begin : g_bad_pid
      $error("PID_W must lie in 1..8");
   end
   if (TS_W < 2 || TS_W > 32) begin : g_bad_ts
      $error("TS_W must lie in 2..32");
   end

   logic [TS_W-1:0] rd_ts;
   logic            rd_vld;
   logic            clr_en;

   lt_stamp_table #(
      .NODES (NODES),
      .PID_W (PID_W),
      .TS_W  (TS_W),
      .NODE_W(NODE_W)
   ) u_table (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (inj_valid),
      .wr_src(inj_src),
      .wr_pid(inj_pid),
      .wr_ts (net_cycle),
      .rd_src(arr_src),
      .rd_pid(arr_pid),
      .clr_en(clr_en),
      .rd_ts (rd_ts),
      .rd_vld(rd_vld)
   );

   lt_latency_calc #(
      .PID_W (PID_W),
      .TS_W  (TS_W),
      .NODE_W(NODE_W)
   ) u_calc (
      .clk       (clk),
      .rst_n     (rst_n),
      .arr_valid (arr_valid),
      .arr_src   (arr_src),
      .arr_pid   (arr_pid),
      .arr_dest  (arr_dest),
      .rx_node   (rx_node),
      .now       (net_cycle),
      .rd_ts     (rd_ts),
      .rd_vld    (rd_vld),
      .clr_en    (clr_en),
      .lat_valid (lat_valid),
      .lat_cycles(lat_cycles),
      .lat_src   (lat_src),
      .lat_pid   (lat_pid),
      .err_dest  (err_dest),
      .err_stale (err_stale)
   );
endmodule

// File: rtl/lt_chk.sv
module lt_chk #(
   parameter int NODES  = 4,
   parameter int PID_W  = 2,
   parameter int TS_W   = 16,
   parameter int NODE_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [TS_W-1:0]   net_cycle,
   input logic [NODE_W-1:0] rx_node,
   input logic              inj_valid,
   input logic [NODE_W-1:0] inj_src,
   input logic [PID_W-1:0]  inj_pid,
   input logic              arr_valid,
   input logic [NODE_W-1:0] arr_src,
   input logic [PID_W-1:0]  arr_pid,
   input logic [NODE_W-1:0] arr_dest,
   input logic              lat_valid,
   input logic [TS_W-1:0]   lat_cycles,
   input logic [NODE_W-1:0] lat_src,
   input logic [PID_W-1:0]  lat_pid,
   input logic              err_dest,
   input logic              err_stale
);
   AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({lat_valid, err_dest, err_stale})); // R10

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !arr_valid |=> !(lat_valid || err_dest || err_stale)); // R10

   AST_ECHO_IDS: assert property (@(posedge clk) disable iff (!rst_n)
      arr_valid |=> (lat_src == $past(arr_src)) && (lat_pid == $past(arr_pid))); // R2

   AST_DEST_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_valid && arr_dest != rx_node) |=> err_dest); // R4

   AST_SAME_CYCLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_valid && inj_valid && inj_src == arr_src && inj_pid == arr_pid
       && arr_dest == rx_node) |=> (lat_valid && lat_cycles == '0)); // R7
endmodule

bind pkt_latency_tracker lt_chk #(
   .NODES (NODES),
   .PID_W (PID_W),
   .TS_W  (TS_W),
   .NODE_W(NODE_W)
) u_chk (.*);

// File: tb/tb_pkt_latency_tracker.sv
module tb_pkt_latency_tracker;
   localparam int NODES = 4;
   localparam int PID_W = 2;
   localparam int TS_W  = 16;
   localparam int NW    = 2;
   localparam int SLOTS = 1 << PID_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [TS_W-1:0] now = '0;
   logic            now_ld = 1'b0;
   logic [TS_W-1:0] now_val = '0;
   always @(posedge clk) now <= now_ld ? now_val : now + 1'b1;

   logic [NW-1:0]    rx_node = '0;
   logic             inj_valid = 1'b0, arr_valid = 1'b0;
   logic [NW-1:0]    inj_src = '0, arr_src = '0, arr_dest = '0;
   logic [PID_W-1:0] inj_pid = '0, arr_pid = '0;
   logic             lat_valid, err_dest, err_stale;
   logic [TS_W-1:0]  lat_cycles;
   logic [NW-1:0]    lat_src;
   logic [PID_W-1:0] lat_pid;

   pkt_latency_tracker #(.NODES(NODES), .PID_W(PID_W), .TS_W(TS_W)) dut (
      .clk(clk), .rst_n(rst_n), .net_cycle(now), .rx_node(rx_node),
      .inj_valid(inj_valid), .inj_src(inj_src), .inj_pid(inj_pid),
      .arr_valid(arr_valid), .arr_src(arr_src), .arr_pid(arr_pid),
      .arr_dest(arr_dest), .lat_valid(lat_valid), .lat_cycles(lat_cycles),
      .lat_src(lat_src), .lat_pid(lat_pid), .err_dest(err_dest),
      .err_stale(err_stale));

   int compared = 0;
   int mismatched = 0;
   logic [TS_W-1:0] m_ts [NODES*SLOTS];
   bit              m_vld [NODES*SLOTS];

   task automatic cmp(input string tag, input string what, input longint got, input longint exp);
      compared++;
      if (got != exp) begin
         mismatched++;
         $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
      end
   endtask

   // One cycle: drive at a falling edge, model, check at the next falling edge.
   task automatic step(input bit iv, input int is, input int ip,
                       input bit av, input int as_, input int ap, input int ad,
                       input string tag);
      bit ok, ed, es;
      logic [TS_W-1:0] elat;
      int idx;
      inj_valid = iv; inj_src = NW'(is); inj_pid = PID_W'(ip);
      arr_valid = av; arr_src = NW'(as_); arr_pid = PID_W'(ap); arr_dest = NW'(ad);
      if (iv) begin
         m_ts[is*SLOTS+ip]  = now;
         m_vld[is*SLOTS+ip] = 1'b1;
      end
      ok = 0; ed = 0; es = 0; elat = '0;
      if (av) begin
         idx = as_*SLOTS + ap;
         if (NW'(ad) != rx_node) ed = 1;
         else if (!m_vld[idx]) es = 1;
         else begin
            ok = 1;
            elat = now - m_ts[idx];
            m_vld[idx] = 1'b0;
         end
      end
      @(negedge clk);
      cmp(tag, "flags{lat,dest,stale}", {lat_valid, err_dest, err_stale}, {ok, ed, es});
      if (ok) begin
         cmp(tag, "lat_cycles", lat_cycles, elat);
         cmp(tag, "lat_src", lat_src, as_);
         cmp(tag, "lat_pid", lat_pid, ap);
      end
      inj_valid = 1'b0; arr_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, 0, 0, "R10");
   endtask

   task automatic load_now(input logic [TS_W-1:0] v);
      now_ld = 1'b1; now_val = v;
      @(negedge clk);
      now_ld = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      for (int i = 0; i < NODES*SLOTS; i++) begin m_ts[i] = '0; m_vld[i] = 1'b0; end
      rx_node = NW'(2);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state of outputs
      cmp("R1", "outputs", {lat_valid, err_dest, err_stale, lat_cycles, lat_src, lat_pid}, 0);
      // R1: every slot empty after reset
      for (int s = 0; s < NODES; s++)
         for (int p = 0; p < SLOTS; p++) step(0, 0, 0, 1, s, p, 2, "R1");
      // R8: fill every slot, then drain in reverse order with gaps
      for (int s = 0; s < NODES; s++)
         for (int p = 0; p < SLOTS; p++) begin
            step(1, s, p, 0, 0, 0, 0, "R8");
            idle(s + p);
         end
      idle(5);
      for (int s = NODES-1; s >= 0; s--)
         for (int p = SLOTS-1; p >= 0; p--) begin
            step(0, 0, 0, 1, s, p, 2, "R2");
            idle(p);
         end
      // R6: repeat arrivals find freed slots
      for (int s = 0; s < NODES; s++)
         for (int p = 0; p < SLOTS; p++) step(0, 0, 0, 1, s, p, 2, "R6");
      // R4: mismatch keeps slot, correct arrival succeeds
      step(1, 1, 3, 0, 0, 0, 0, "R4");
      idle(4);
      step(0, 0, 0, 1, 1, 3, 0, "R4");
      step(0, 0, 0, 1, 1, 3, 3, "R4");
      idle(2);
      step(0, 0, 0, 1, 1, 3, 2, "R4");
      // R5: stale arrival on a never-filled slot
      step(0, 0, 0, 1, 3, 1, 2, "R5");
      // R7: same-cycle inject and arrival, then slot is empty
      step(1, 2, 2, 1, 2, 2, 2, "R7");
      step(0, 0, 0, 1, 2, 2, 2, "R7");
      // R8: simultaneous inject and arrival on different slots
      step(1, 0, 1, 0, 0, 0, 0, "R8");
      step(1, 3, 0, 1, 0, 1, 2, "R8");
      idle(3);
      step(0, 0, 0, 1, 3, 0, 2, "R8");
      // R3: wrap of the cycle counter
      load_now(16'hFFF0);
      step(1, 2, 1, 0, 0, 0, 0, "R3");
      idle(31);
      step(0, 0, 0, 1, 2, 1, 2, "R3");
      load_now(16'hFFFF);
      step(1, 0, 3, 0, 0, 0, 0, "R3");
      step(0, 0, 0, 1, 0, 3, 2, "R3");
      // R9: overwrite of an occupied slot
      step(1, 0, 0, 0, 0, 0, 0, "R9");
      idle(5);
      step(1, 0, 0, 0, 0, 0, 0, "R9");
      idle(3);
      step(0, 0, 0, 1, 0, 0, 2, "R9");
      step(0, 0, 0, 1, 0, 0, 2, "R9");
      // R2: each receiving node number accepts its own packets
      for (int n = 0; n < NODES; n++) begin
         rx_node = NW'(n);
         step(1, (n + 1) % NODES, n % SLOTS, 0, 0, 0, 0, "R2");
         idle(n * 7 + 1);
         step(0, 0, 0, 1, (n + 1) % NODES, n % SLOTS, (n + 1) % NODES, "R4");
         step(0, 0, 0, 1, (n + 1) % NODES, n % SLOTS, n, "R2");
      end
      // R10: quiet after idle
      idle(3);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule